// File: doc/BRIEF.md
# Four-Pin GPIO Set/Clear Register Block

This block gives a bus master control over four general-purpose pins through a single 32-bit register word. The word sits at one dword address on a simple synchronous register bus and is reached with per-byte, active-low lane enables. Byte lane 1 holds the output data value. Byte lane 2 holds two write-only-in-effect fields that switch output drivers on and off. Byte lane 3 returns the pin levels.

The output-enable state cannot be written directly. A 1 in the upper nibble of lane 2 turns a pin's driver on. A 1 in the lower nibble turns it off. A 0 in either nibble leaves the pin as it was. Reading lane 2 returns the two nibbles exactly as they were last written, not the enable state they produced. Pin inputs pass through a two-flop synchronizer and then a capture register before they reach the read path.

Top module: `gpio_setclr_regs`

## Requirements
- R1: After reset, every output enable is 0, the output data is 0, both lane-2 nibbles read back as 0, and the read data is 0.
- R2: A selected lane-2 write sets the output enable of pin i for every 1 in bit 20+i. A 0 in bits 23:20 leaves that pin's enable unchanged.
- R3: A selected lane-2 write clears the output enable of pin i for every 1 in bit 16+i. A 0 in bits 19:16 leaves that pin's enable unchanged.
- R4: When one write has bit 20+i and bit 16+i both at 1, pin i ends with its output enable at 0.
- R5: Reading bits 23:20 and 19:16 returns the value last written to each nibble, independent of the current enable state.
- R6: Bits 11:8 (lane 1) hold the output data, which reads back as written. Bits 15:12 read as 0. Output pin i carries data bit i while its enable is 1 and is 0 otherwise. The enable port shows the enable state.
- R7: Bits 27:24 and lane 0 (bits 7:0) always read as 0, and writes to them change nothing.
- R8: Bits 31:28 read the pin levels. A pin change driven before clock edge k is captured at edge k+2 and returned by a read strobe sampled at edge k+3 or later.
- R9: A lane is written only when its active-low enable bit is 0. A write with all enables at 1 changes nothing. On a read, lanes whose enable bit is 1 return 0.
- R10: An access whose address bits above bit 1 differ from the block's dword address (64h) writes nothing, and a read of such an address returns 0.
- R11: Read data is registered. It updates on the clock edge that samples the read strobe and holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_be_n | input | 4 | Active-low byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 4 | Pin levels, asynchronous |
| pin_out | output | 4 | Output value per pin |
| pin_oe | output | 4 | Output driver enable per pin |

## Verification
On every cycle the checker confirms that the enable state moves only on a selected lane-2 write and follows set-then-clear resolution, that no pin shows a 1 on its output while its driver is off, that the reserved and lane-0 bits of the read word stay 0, and that the read word holds between strobes. The bench's scenarios show what per-cycle properties cannot: that the lane-2 readback returns the written nibbles rather than the enable state, that a pin change takes exactly three edges to reach a read, and that partial lane enables and a foreign address leave every field as it was.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

    localparam int NPIN      = 4;
    localparam int WORD_W    = 32;
    localparam int NLANE     = WORD_W / 8;

    localparam int LANE_DATA = 1;
    localparam int LANE_EN   = 2;

    localparam int DATA_LSB  = 8;
    localparam int CLR_LSB   = 16;
    localparam int SET_LSB   = 20;
    localparam int IN_LSB    = 28;

    typedef logic [NPIN-1:0]   pin_vec_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NLANE-1:0]  lane_n_t;

    typedef struct packed {
        logic     valid;
        pin_vec_t set_bits;
        pin_vec_t clr_bits;
    } en_wr_t;

    typedef struct packed {
        pin_vec_t in_lvl;
        pin_vec_t set_last;
        pin_vec_t clr_last;
        pin_vec_t out_data;
    } rd_fields_t;

    function automatic logic lane_on(lane_n_t be_n, int lane);
        return ~be_n[lane];
    endfunction

    function automatic word_t lane_mask(lane_n_t be_n);
        word_t m;
        for (int i = 0; i < NLANE; i++) begin
            m[i*8 +: 8] = {8{~be_n[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/gsc_in_sync.sv
module gsc_in_sync
    import gpio_setclr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pin_raw,
    output pin_vec_t pin_cap
);

    pin_vec_t chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= pin_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pin_cap <= '0;
        else     pin_cap <= chain[STAGES-1];
    end

endmodule

// File: rtl/gsc_en_ctrl.sv
module gsc_en_ctrl
    import gpio_setclr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  en_wr_t   en_wr,
    output pin_vec_t en_state,
    output pin_vec_t set_last,
    output pin_vec_t clr_last
);

    pin_vec_t en_next;

    always_comb begin
        en_next = en_state;
        if (en_wr.valid) begin
            en_next = (en_state | en_wr.set_bits) & ~en_wr.clr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_state <= '0;
            set_last <= '0;
            clr_last <= '0;
        end else begin
            en_state <= en_next;
            if (en_wr.valid) begin
                set_last <= en_wr.set_bits;
                clr_last <= en_wr.clr_bits;
            end
        end
    end

endmodule

// File: rtl/gsc_rd_mux.sv
module gsc_rd_mux
    import gpio_setclr_pkg::*;
(
    input  rd_fields_t fields,
    input  lane_n_t    be_n,
    output word_t      word
);

    word_t raw;

    always_comb begin
        raw = '0;
        raw[DATA_LSB +: NPIN] = fields.out_data;
        raw[CLR_LSB  +: NPIN] = fields.clr_last;
        raw[SET_LSB  +: NPIN] = fields.set_last;
        raw[IN_LSB   +: NPIN] = fields.in_lvl;
        word = raw & lane_mask(be_n);
    end

endmodule

// File: rtl/gpio_setclr_regs.sv
module gpio_setclr_regs
    import gpio_setclr_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  DWORD_ADDR  = 8'h64,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be_n,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        pin_in,
    output logic [3:0]        pin_out,
    output logic [3:0]        pin_oe
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DWORD_ADDR);

    logic       addr_hit;
    en_wr_t     en_wr;
    pin_vec_t   en_state, set_last, clr_last, in_cap;
    pin_vec_t   out_data;
    rd_fields_t fields;
    word_t      rd_word;

    assign addr_hit = (bus_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);

    always_comb begin
        en_wr.valid    = bus_wr && addr_hit && lane_on(bus_be_n, LANE_EN);
        en_wr.set_bits = bus_wdata[SET_LSB +: NPIN];
        en_wr.clr_bits = bus_wdata[CLR_LSB +: NPIN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
        end else if (bus_wr && addr_hit && lane_on(bus_be_n, LANE_DATA)) begin
            out_data <= bus_wdata[DATA_LSB +: NPIN];
        end
    end

    gsc_en_ctrl u_en (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (en_wr),
        .en_state (en_state),
        .set_last (set_last),
        .clr_last (clr_last)
    );

    gsc_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_in),
        .pin_cap (in_cap)
    );

    always_comb begin
        fields.in_lvl   = in_cap;
        fields.set_last = set_last;
        fields.clr_last = clr_last;
        fields.out_data = out_data;
    end

    gsc_rd_mux u_mux (
        .fields (fields),
        .be_n   (bus_be_n),
        .word   (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= addr_hit ? rd_word : '0;
        end
    end

    assign pin_oe  = en_state;
    assign pin_out = out_data & en_state;

endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk #(
    parameter int         ADDR_W     = 8,
    parameter logic [7:0] DWORD_ADDR = 8'h64
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be_n,
    input logic [31:0]       bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [3:0]        pin_out,
    input logic [3:0]        pin_oe
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DWORD_ADDR);

    logic en_write;
    assign en_write = bus_wr && !bus_be_n[2] &&
                      (bus_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == 4'h0 && bus_rdata == 32'h0));

    assert_setclr_R2_R3_R4: assert property (@(posedge clk) disable iff (rst)
        en_write |=> pin_oe == (($past(pin_oe) | $past(bus_wdata[23:20]))
                                & ~$past(bus_wdata[19:16])));

    assert_no_stray_R9_R10: assert property (@(posedge clk) disable iff (rst)
        !en_write |=> $stable(pin_oe));

    assert_drive_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == 4'h0);

    assert_zero_bits_R7: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[27:24] == 4'h0 && bus_rdata[15:12] == 4'h0 && bus_rdata[7:0] == 8'h0);

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_setclr_regs gpio_setclr_chk #(
    .ADDR_W     (ADDR_W),
    .DWORD_ADDR (DWORD_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_be_n  (bus_be_n),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_setclr_regs_tb.sv
module gpio_setclr_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h64;
    logic [3:0]  bus_be_n = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  pin_in = 4'h0;
    logic [3:0]  pin_out;
    logic [3:0]  pin_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } rd_item_t;

    rd_item_t exp_q[$];

    always #10 clk = ~clk;

    gpio_setclr_regs u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_be_n  (bus_be_n),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge, returns at the next negedge.
    task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        bus_addr = a; bus_be_n = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be_n = 4'hF;
    endtask

    task automatic rd(logic [7:0] a, logic [3:0] be, logic [31:0] exp, string req);
        rd_item_t it;
        it.exp = exp; it.req = req;
        exp_q.push_back(it);
        bus_addr = a; bus_be_n = be; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_be_n = 4'hF;
    endtask

    task automatic pins(string req, logic [3:0] oe, logic [3:0] o);
        check({req, " oe"},  {28'h0, pin_oe},  {28'h0, oe});
        check({req, " out"}, {28'h0, pin_out}, {28'h0, o});
    endtask

    // Monitor: pop one expected item per sampled read strobe.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("scoreboard", 32'h1, 32'h0);
                end else begin
                    rd_item_t it;
                    it = exp_q.pop_front();
                    check(it.req, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        pins("R1", 4'h0, 4'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rd(8'h64, 4'h0, 32'h0000_0000, "R1 full word");

        // R6 output data, upper nibble of lane 1 ignored, no drive while disabled
        wr(8'h64, 4'b1101, 32'h0000_FA00);
        pins("R6 disabled", 4'h0, 4'h0);
        rd(8'h64, 4'b1101, 32'h0000_0A00, "R6 data readback");

        // R2 set, zeros leave pins alone
        wr(8'h64, 4'b1011, 32'h0050_0000);
        pins("R2 set 5", 4'h5, 4'h0);
        wr(8'h64, 4'b1011, 32'h0020_0000);
        pins("R2 set 2", 4'h7, 4'h2);

        // R5 readback is the last written nibbles, not the enable state
        rd(8'h64, 4'b1011, 32'h0020_0000, "R5 readback");

        // R3 clear
        wr(8'h64, 4'b1011, 32'h0001_0000);
        pins("R3 clr 1", 4'h6, 4'h2);
        rd(8'h64, 4'b1011, 32'h0001_0000, "R5 readback after clear");

        // R4 both set and clear on bit 2: clear wins
        wr(8'h64, 4'b1011, 32'h00C4_0000);
        pins("R4 clear wins", 4'hA, 4'hA);

        // R9 no lane enabled
        wr(8'h64, 4'b1111, 32'h00F0_FF00);
        pins("R9 no lanes", 4'hA, 4'hA);
        rd(8'h64, 4'h0, 32'h00C4_0A00, "R9 unchanged");

        // R9 lane 2 deselected, lanes 0,1,3 selected
        wr(8'h64, 4'b0100, 32'hFFFF_FFFF);
        pins("R9 lane2 off", 4'hA, 4'hA);
        rd(8'h64, 4'b1011, 32'h00C4_0000, "R9 lane2 kept");
        rd(8'h64, 4'b1101, 32'h0000_0F00, "R9 lane1 written");

        // R10 foreign address
        wr(8'h60, 4'h0, 32'h000F_0000);
        pins("R10 foreign write", 4'hA, 4'hA);
        rd(8'h60, 4'h0, 32'h0, "R10 foreign read");
        rd(8'h67, 4'h0, 32'h00C4_0F00, "R10 byte offset ignored");

        // R7 reserved and lane 0
        wr(8'h64, 4'b0110, 32'hFF00_00FF);
        rd(8'h64, 4'h0, 32'h00C4_0F00, "R7 reserved and lane0");

        // R8 input latency
        pin_in = 4'h9;
        @(negedge clk);
        @(negedge clk);
        rd(8'h64, 4'b0111, 32'h0000_0000, "R8 not yet visible");
        rd(8'h64, 4'b0111, 32'h9000_0000, "R8 visible");
        rd(8'h64, 4'h0, 32'h90C4_0F00, "R8 full word");

        // R11 hold between strobes
        repeat (4) @(negedge clk);
        check("R11 hold", bus_rdata, 32'h90C4_0F00);
        pin_in = 4'h0;
        repeat (5) @(negedge clk);
        check("R11 hold after pin change", bus_rdata, 32'h90C4_0F00);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pins("R1 re-reset", 4'h0, 4'h0);
        rd(8'h64, 4'b1001, 32'h0, "R1 fields cleared");

        repeat (2) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule